// File: doc/BRIEF.md
# Event-Action PWM Generator

This block drives one pulse-width-modulated output from a 16-bit timebase counter. The counter can count up, count down, or count up and then down. It advances once per prescaled tick, where the divider ratio is a 12-bit value. The waveform comes from four counter events rather than from a fixed compare-against-duty rule:

- the counter reaching zero;
- the counter meeting the compare value while counting upward;
- the counter reaching the period value;
- the counter meeting the compare value while counting downward.

Each event carries a 2-bit action that holds, clears, sets or toggles the output. This lets software build edge-aligned, center-aligned or asymmetric waveforms.

The period and compare inputs are buffered. The counter copies them into its working registers only at the boundary between two PWM periods, so a value written part-way through a period never cuts that period short. A period of zero parks the counter.

Two overrides act after the waveform logic. A mask forces the output to a chosen level. A polarity control then inverts whatever the mask stage produces. Each counter event is also available as a one-clock strobe, so neighbouring logic can synchronise to the timebase.

Top module: `pwm_evt_gen`

## Requirements
- R1: The counter advances only on prescaler ticks, which occur once every (div + 1) clocks for the 12-bit divider value div. With div = 2 and period 3 in up mode, two successive zero strobes are 12 clocks apart.
- R2: In mode code 0 (up), the counter runs 0, 1, …, P and then returns to 0.
  - The zero strobe pulses on arriving at 0.
  - The period strobe pulses on arriving at P.
  - The compare-up strobe pulses on arriving at the compare value.
  - Successive zero strobes are (P + 1) ticks apart.
- R3: In mode code 1 (down), the counter reloads P after 0 and then counts P, P−1, …, 0.
  - The period strobe pulses on the reload.
  - The zero strobe pulses on arriving at 0.
  - Compare matches pulse the compare-down strobe.
- R4: In mode code 2 (up-down), the counter climbs from 0 to P and then falls back to 0, so successive zero strobes are 2·P ticks apart.
  - Zero fires only at the bottom and period only at the top.
  - A compare match pulses compare-up while rising and compare-down while falling.
- R5: The action codes are 0 = hold, 1 = drive low, 2 = drive high and 3 = toggle.
  - The selected action updates the output on the same clock edge on which the matching strobe rises.
  - The output never changes between events.
- R6: When a zero or period event coincides with a compare event, only the zero or period action is applied.
- R7: The period and compare inputs are sampled only at the load point: on the wrap to 0 in up mode, and when the counter leaves 0 in down and up-down modes. Changes made mid-period take effect from the next period.
- R8: While the working period is 0, the counter stays at 0, no strobe pulses and the output holds. A non-zero period input is picked up on the next tick.
- R9: With the mask enabled, the output equals the mask level whatever the waveform is. Clearing the mask returns the generated waveform.
- R10: The polarity control inverts the final output, applied after the mask.
- R11: A synchronous active-low reset clears the following: the prescaler, the counter, the working period and compare (which parks the block), the output state and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | 12 | Prescaler divider; ticks every clk_div+1 clocks |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up-down (3 behaves as up) |
| period_in | input | 16 | Buffered period value |
| compare_in | input | 16 | Buffered compare value |
| act_zero | input | 2 | Action at the zero event |
| act_cmp_up | input | 2 | Action at compare while counting up |
| act_period | input | 2 | Action at the period event |
| act_cmp_dn | input | 2 | Action at compare while counting down |
| mask_en | input | 1 | Force output to mask_level |
| mask_level | input | 1 | Level used while masked |
| invert | input | 1 | Invert the final output |
| pwm_out | output | 1 | PWM output |
| ev_zero | output | 1 | Zero event strobe |
| ev_cmp_up | output | 1 | Compare-while-up event strobe |
| ev_period | output | 1 | Period event strobe |
| ev_cmp_dn | output | 1 | Compare-while-down event strobe |

## Verification
The bench aims at the following corner cases.

- A compare value of zero in up mode. Here the zero and compare-up events coincide; a design with the wrong priority would let the compare action clear the output that the zero action had just set.
- A period rewrite in the middle of a period. An unbuffered design would shorten the running period instead of the next one.
- The up-down turnaround. A design that fires the zero or period event on both passes would double the strobe rate.
- A period of zero. A design without this case would emit a zero strobe on every tick.
- The order of mask and inversion. This is probed with the mask set and then cleared, where a swapped order gives the opposite level.

Beyond these, random modes, dividers and actions are compared cycle by cycle against a reference model built from the requirements.

// File: rtl/pwm_evt_pkg.sv
// Shared types for the event-action PWM generator.
// Assumes: codes below are fixed by the register contract of the block.
package pwm_evt_pkg;

    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_UPDOWN = 2'd2,
        CNT_RSVD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } out_act_e;

    typedef struct packed {
        logic zero;
        logic cmp_up;
        logic period;
        logic cmp_dn;
    } evt_t;

endpackage

// File: rtl/pwm_evt_prescale.sv
// Tick generator: asserts tick_o for one clock every div_i+1 clocks.
// Assumes: div_i may change at any time; an oversized count ticks at once.
module pwm_evt_prescale #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [PSC_W-1:0] PSC_ONE = {{(PSC_W-1){1'b0}}, 1'b1};

    logic [PSC_W-1:0] pcnt_q;

    assign tick_o = (pcnt_q >= div_i);

    // Count clocks between ticks, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (tick_o) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + PSC_ONE;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || !$stable(div_i))); // R1

endmodule

// File: rtl/pwm_evt_timebase.sv
// Timebase counter with buffered period/compare and event detection.
// Assumes: evt_nxt_o describes the value the counter takes at the coming
// edge (gated by tick_i); evt_o is the registered strobe of the same events.
module pwm_evt_timebase
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  cnt_mode_e        mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output evt_t             evt_nxt_o,
    output evt_t             evt_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, per_q, cmp_q;
    logic             up_q;
    evt_t             evt_q;

    logic [CNT_W-1:0] nxt_cnt, nxt_per, nxt_cmp;
    logic             nxt_up, arrived_up, load, running;

    // Next counter value, direction and load decision for the active mode.
    always_comb begin
        nxt_cnt    = cnt_q;
        nxt_up     = up_q;
        load       = 1'b0;
        arrived_up = 1'b1;
        case (mode_i)
            CNT_DOWN: begin
                arrived_up = 1'b0;
                if (cnt_q == '0) begin
                    load    = 1'b1;
                    nxt_cnt = period_i;
                end else begin
                    nxt_cnt = cnt_q - CNT_ONE;
                end
            end
            CNT_UPDOWN: begin
                if (cnt_q == '0) begin
                    load    = 1'b1;
                    nxt_up  = 1'b1;
                    nxt_cnt = (period_i == '0) ? '0 : CNT_ONE;
                end else if (up_q && cnt_q >= per_q) begin
                    nxt_up  = 1'b0;
                    nxt_cnt = cnt_q - CNT_ONE;
                end else if (up_q) begin
                    nxt_cnt = cnt_q + CNT_ONE;
                end else begin
                    nxt_cnt = cnt_q - CNT_ONE;
                end
                arrived_up = (nxt_cnt > cnt_q);
            end
            default: begin
                if (cnt_q >= per_q) begin
                    load    = 1'b1;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = cnt_q + CNT_ONE;
                end
            end
        endcase
        nxt_per = load ? period_i  : per_q;
        nxt_cmp = load ? compare_i : cmp_q;
    end

    // Events seen on arrival at the next counter value.
    always_comb begin
        running          = (nxt_per != '0);
        evt_nxt_o.zero   = tick_i && running && (nxt_cnt == '0);
        evt_nxt_o.period = tick_i && running && (nxt_cnt == nxt_per);
        evt_nxt_o.cmp_up = tick_i && running && (nxt_cnt == nxt_cmp) && arrived_up;
        evt_nxt_o.cmp_dn = tick_i && running && (nxt_cnt == nxt_cmp) && !arrived_up;
    end

    // Advance counter state on ticks; register strobes every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
            cmp_q <= '0;
            up_q  <= 1'b1;
            evt_q <= '0;
        end else begin
            evt_q <= evt_nxt_o;
            if (tick_i) begin
                cnt_q <= nxt_cnt;
                per_q <= nxt_per;
                cmp_q <= nxt_cmp;
                up_q  <= nxt_up;
            end
        end
    end

    assign evt_o = evt_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> (cnt_q <= per_q)); // R2
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0) |-> (cnt_q == '0 && evt_q == '0)); // R8

endmodule

// File: rtl/pwm_evt_action.sv
// Output state machine: applies the per-event action to the waveform bit.
// Assumes: evt_i is the event set for the coming edge; zero and period
// outweigh the compare events when they coincide.
module pwm_evt_action
    import pwm_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_t     evt_i,
    input  out_act_e act_zero_i,
    input  out_act_e act_cmp_up_i,
    input  out_act_e act_period_i,
    input  out_act_e act_cmp_dn_i,
    output logic     wave_o
);
    out_act_e sel;
    logic     wave_q;

    // Pick a single action, boundary events first.
    always_comb begin
        if (evt_i.zero)        sel = act_zero_i;
        else if (evt_i.period) sel = act_period_i;
        else if (evt_i.cmp_up) sel = act_cmp_up_i;
        else if (evt_i.cmp_dn) sel = act_cmp_dn_i;
        else                   sel = ACT_HOLD;
    end

    // Apply the selected action to the waveform bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            case (sel)
                ACT_LOW:    wave_q <= 1'b0;
                ACT_HIGH:   wave_q <= 1'b1;
                ACT_TOGGLE: wave_q <= ~wave_q;
                default:    wave_q <= wave_q;
            endcase
        end
    end

    assign wave_o = wave_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> $stable(wave_q)); // R5
    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.zero && act_zero_i == ACT_HOLD) |=> $stable(wave_q)); // R6
    AST_PERIOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.period && !evt_i.zero && act_period_i == ACT_HIGH) |=> wave_q); // R5

endmodule

// File: rtl/pwm_evt_gen.sv
// Event-action PWM generator top: prescaler, timebase, action unit, then
// mask and polarity on the output path.
// Assumes: configuration inputs are static or change synchronously to clk.
module pwm_evt_gen
    import pwm_evt_pkg::*;
#(
    parameter int PSC_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] clk_div,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] compare_in,
    input  logic [1:0]       act_zero,
    input  logic [1:0]       act_cmp_up,
    input  logic [1:0]       act_period,
    input  logic [1:0]       act_cmp_dn,
    input  logic             mask_en,
    input  logic             mask_level,
    input  logic             invert,
    output logic             pwm_out,
    output logic             ev_zero,
    output logic             ev_cmp_up,
    output logic             ev_period,
    output logic             ev_cmp_dn
);
    logic tick;
    evt_t evt_nxt, evt_reg;
    logic wave;

    pwm_evt_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (clk_div),
        .tick_o (tick)
    );

    pwm_evt_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .mode_i    (cnt_mode_e'(cnt_mode)),
        .period_i  (period_in),
        .compare_i (compare_in),
        .evt_nxt_o (evt_nxt),
        .evt_o     (evt_reg)
    );

    pwm_evt_action u_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_nxt),
        .act_zero_i   (out_act_e'(act_zero)),
        .act_cmp_up_i (out_act_e'(act_cmp_up)),
        .act_period_i (out_act_e'(act_period)),
        .act_cmp_dn_i (out_act_e'(act_cmp_dn)),
        .wave_o       (wave)
    );

    // Override stage, then polarity, on the way to the pin.
    always_comb begin
        pwm_out = (mask_en ? mask_level : wave) ^ invert;
    end

    assign ev_zero   = evt_reg.zero;
    assign ev_cmp_up = evt_reg.cmp_up;
    assign ev_period = evt_reg.period;
    assign ev_cmp_dn = evt_reg.cmp_dn;

endmodule

// File: tb/tb_pwm_evt_gen.sv
module tb_pwm_evt_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] clk_div = '0;
    logic [1:0]  cnt_mode = '0;
    logic [15:0] period_in = '0, compare_in = '0;
    logic [1:0]  act_zero = '0, act_cmp_up = '0, act_period = '0, act_cmp_dn = '0;
    logic        mask_en = 1'b0, mask_level = 1'b0, invert = 1'b0;
    logic        pwm_out, ev_zero, ev_cmp_up, ev_period, ev_cmp_dn;

    int vectors = 0, fails = 0, cyc = 0, last_zero = 0, gap = 0, strobes = 0;

    // reference model state
    int m_pcnt, m_cnt, m_per, m_cmp;
    bit m_up, m_wave, e_z, e_u, e_p, e_d;

    pwm_evt_gen dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired got=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Model of one clock edge, written from the requirement list.
    task automatic model_step();
        int nc; bit up; bit ld; int a;
        e_z = 0; e_u = 0; e_p = 0; e_d = 0;
        if (!rst_n) begin
            m_pcnt = 0; m_cnt = 0; m_per = 0; m_cmp = 0; m_up = 1; m_wave = 0;
            return;
        end
        if (m_pcnt < int'(clk_div)) begin
            m_pcnt++;
            return;
        end
        m_pcnt = 0;
        ld = 0; up = 1; nc = m_cnt;
        case (cnt_mode)
            2'd1: begin
                up = 0;
                if (m_cnt == 0) begin ld = 1; nc = int'(period_in); end
                else nc = m_cnt - 1;
            end
            2'd2: begin
                if (m_cnt == 0) begin ld = 1; m_up = 1; nc = (period_in == 0) ? 0 : 1; end
                else if (m_up && m_cnt >= m_per) begin m_up = 0; nc = m_cnt - 1; end
                else nc = m_up ? m_cnt + 1 : m_cnt - 1;
                up = (nc > m_cnt);
            end
            default: begin
                if (m_cnt >= m_per) begin ld = 1; nc = 0; end
                else nc = m_cnt + 1;
            end
        endcase
        if (ld) begin m_per = int'(period_in); m_cmp = int'(compare_in); end
        m_cnt = nc;
        if (m_per != 0) begin
            e_z = (nc == 0);
            e_p = (nc == m_per);
            e_u = (nc == m_cmp) && up;
            e_d = (nc == m_cmp) && !up;
        end
        a = e_z ? int'(act_zero) : e_p ? int'(act_period) :
            e_u ? int'(act_cmp_up) : e_d ? int'(act_cmp_dn) : 0;
        case (a)
            1: m_wave = 0;
            2: m_wave = 1;
            3: m_wave = ~m_wave;
            default: ;
        endcase
    endtask

    task automatic step(input string tag);
        logic [4:0] got, exp;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        exp = {(mask_en ? mask_level : m_wave) ^ invert, e_z, e_u, e_p, e_d};
        got = {pwm_out, ev_zero, ev_cmp_up, ev_period, ev_cmp_dn};
        check(got === exp, tag, int'(got), int'(exp));
        if (ev_zero) begin gap = cyc - last_zero; last_zero = cyc; end
        if (ev_zero | ev_cmp_up | ev_period | ev_cmp_dn) strobes++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step("R11");
        step("R11");
        rst_n = 1'b1;
    endtask

    task automatic wait_zero(input string tag);
        for (int i = 0; i < 3000; i++) begin
            step(tag);
            if (ev_zero) return;
        end
    endtask

    task automatic setup(input int md, input int dv, input int p, input int c,
                         input int az, input int au, input int ap, input int ad);
        cnt_mode = 2'(md); clk_div = 12'(dv); period_in = 16'(p); compare_in = 16'(c);
        act_zero = 2'(az); act_cmp_up = 2'(au); act_period = 2'(ap); act_cmp_dn = 2'(ad);
        mask_en = 0; mask_level = 0; invert = 0;
        do_reset();
    endtask

    initial begin
        void'($urandom(32'd7351));
        do_reset();
        // R11: reset state at the ports
        check({pwm_out, ev_zero, ev_cmp_up, ev_period, ev_cmp_dn} == 5'b0, "R11 reset", 0, 0);

        // R2 / R1: up mode, divider 2, period 3 -> zero every 12 clocks
        setup(0, 2, 3, 1, 2, 1, 0, 0);
        wait_zero("R2"); wait_zero("R2"); wait_zero("R1");
        check(gap == 12, "R1 tick spacing", gap, 12);
        // R2: undivided, period 4 -> zero every 5 clocks
        setup(0, 0, 4, 2, 2, 1, 0, 0);
        wait_zero("R2"); wait_zero("R2"); wait_zero("R2");
        check(gap == 5, "R2 up period", gap, 5);

        // R3: down mode, period 5 -> zero every 6 clocks
        setup(1, 0, 5, 2, 1, 0, 0, 2);
        wait_zero("R3"); wait_zero("R3"); wait_zero("R3");
        check(gap == 6, "R3 down period", gap, 6);

        // R4: up-down, period 4 -> zero every 8 clocks, toggle on compares
        setup(2, 0, 4, 2, 0, 3, 0, 3);
        wait_zero("R4"); wait_zero("R4"); wait_zero("R4");
        check(gap == 8, "R4 up-down period", gap, 8);
        for (int i = 0; i < 20; i++) step("R4/R5");

        // R6: compare 0 coincides with zero; zero sets high, compare-up would clear
        setup(0, 0, 3, 0, 2, 1, 0, 0);
        for (int i = 0; i < 12; i++) step("R6");
        check(pwm_out == 1'b1, "R6 priority", int'(pwm_out), 1);

        // R7: period rewrite mid-period applies from the next period
        setup(0, 0, 9, 3, 2, 1, 0, 0);
        wait_zero("R7"); wait_zero("R7");
        for (int i = 0; i < 3; i++) step("R7");
        period_in = 16'd4;
        wait_zero("R7");
        check(gap == 10, "R7 old period kept", gap, 10);
        wait_zero("R7");
        check(gap == 5, "R7 new period used", gap, 5);

        // R8: period 0 parks the block
        setup(0, 0, 0, 0, 3, 3, 3, 3);
        strobes = 0;
        for (int i = 0; i < 30; i++) step("R8");
        check(strobes == 0, "R8 no strobes", strobes, 0);
        check(pwm_out == 1'b0, "R8 output held", int'(pwm_out), 0);
        period_in = 16'd3;
        wait_zero("R8");
        check(strobes != 0, "R8 restart", strobes, 1);

        // R9 / R10: mask then polarity on a running waveform
        setup(0, 0, 5, 2, 2, 1, 0, 0);
        for (int i = 0; i < 8; i++) step("R9");
        mask_en = 1; mask_level = 1;
        for (int i = 0; i < 7; i++) begin
            step("R9");
            check(pwm_out == 1'b1, "R9 mask high", int'(pwm_out), 1);
        end
        invert = 1;
        step("R10");
        check(pwm_out == 1'b0, "R10 invert after mask", int'(pwm_out), 0);
        mask_en = 0;
        for (int i = 0; i < 12; i++) step("R9/R10");

        // Random rounds: R1/R2/R3/R4/R5/R7 against the model
        for (int r = 0; r < 24; r++) begin
            setup($urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 12),
                  $urandom_range(0, 13), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 3));
            invert = 1'($urandom_range(0, 1));
            for (int i = 0; i < 250; i++) begin
                if ($urandom_range(0, 19) == 0) period_in = 16'($urandom_range(0, 12));
                if ($urandom_range(0, 19) == 0) compare_in = 16'($urandom_range(0, 13));
                if ($urandom_range(0, 39) == 0) begin
                    mask_en = ~mask_en;
                    mask_level = 1'($urandom_range(0, 1));
                end
                step("R1/R2/R3/R4/R5/R7/R9/R10");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule